// File: doc/BRIEF.md
# Three-Channel Intercluster Link Sender

This block sits at the transmitting end of a point-to-point link between two processor clusters. The link is made of three parallel channels. A fast channel is narrow and has the shortest flight time. A baseline channel has moderate width and latency. A wide low-energy channel is the slowest. Each cycle the block takes up to `NREQ` transfer requests. Each request carries a payload, a 3-bit class tag and a destination. The block places every accepted request into one slot of one channel.

Channel choice follows the class of the request and the value of its payload. Small integer results and early partial addresses travel on the fast channel. Traffic that is not time-critical, such as operands sent at dispatch and store data, uses the low-energy channel. Everything else uses the baseline channel. When the preferred channel has no free slot in a cycle, the request falls back to the baseline channel. When the baseline channel is also full, the request is held back through its ready signal.

Each channel's flight time is modelled by a register pipeline. Crossbar latencies are 1, 2 and 3 cycles. Ring latencies are 2, 4 and 6 cycles, selected by a parameter. The receiver sees every payload together with its valid flag, class and destination on its own slot.

Top module: `xls_link_steer`

## Requirements
- R1: Class codes choose the preferred channel. Code 2 (dispatch operand) and code 3 (store data) prefer the low-energy channel. Code 1 (narrow result) and code 4 (low address bits) prefer the fast channel. Code 0 (critical operand) and the unused codes 5 to 7 use the baseline channel.
- R2: A code-1 request whose payload has any bit set at or above position `FAST_W` goes on the baseline channel, even when a fast slot is free.
- R3: A payload delivered on a fast slot carries only its low `FAST_W` bits, and all higher bits are zero. A code-4 request is truncated this way.
- R4: Per cycle, the fast, baseline and low-energy channels hold at most `NF`, `NB` and `NS` transfers. A request whose preferred channel is full is placed on the baseline channel if a baseline slot is free.
- R5: A valid request that finds its preferred channel and the baseline channel full is not accepted. Its ready bit is low and nothing is delivered for it. A ready bit is never high for an invalid lane.
- R6: Lanes are served in index order. A valid lane is accepted only if every lower-indexed valid lane is accepted in the same cycle. Invalid lanes block nothing.
- R7: With `RING` = 0, a request accepted at a clock edge becomes visible at the receiver after 1 edge on the fast channel, 2 edges on the baseline channel and 3 edges on the low-energy channel.
- R8: With `RING` = 1, these latencies are 2, 4 and 6 edges.
- R9: Output slots are numbered fast first, then baseline, then low-energy. Within one channel, a lower lane takes a lower slot. A delivered slot shows the class, destination and payload of its request.
- R10: After reset no slot is valid. Every delivery is valid for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | NREQ | Request valid, one bit per lane |
| req_cls | input | 3*NREQ | Class code, lane i at bits [3i+2:3i] |
| req_dst | input | DSTW*NREQ | Destination per lane |
| req_dat | input | DW*NREQ | Payload per lane |
| req_rdy | output | NREQ | Request accepted this cycle, per lane |
| out_vld | output | NF+NB+NS | Delivery valid per slot |
| out_cls | output | 3*(NF+NB+NS) | Delivered class per slot |
| out_dst | output | DSTW*(NF+NB+NS) | Delivered destination per slot |
| out_dat | output | DW*(NF+NB+NS) | Delivered payload per slot |

## Verification
The sweep is run on two lanes. It covers every pair of class codes, including an unused one, every non-empty lane-valid pattern, and narrow and wide payloads on each lane. Two narrow requests, or two critical requests, set off fallback and stall. Two low-energy requests show slot order. Wide code-1 and code-4 payloads tell width-based rerouting apart from truncation. The same stimulus drives a crossbar and a ring instance, and each slot is sampled on every cycle after acceptance. This separates a wrong latency from a wrong channel choice and catches deliveries that last longer than one cycle.

// File: rtl/xls_pkg.sv
package xls_pkg;

   localparam int CLS_W = 3;

   typedef enum logic [2:0] {
      CLS_CRIT     = 3'd0,
      CLS_NARROW   = 3'd1,
      CLS_DISPATCH = 3'd2,
      CLS_STORE    = 3'd3,
      CLS_ADDRLO   = 3'd4
   } xls_cls_e;

   typedef enum logic [1:0] {
      CH_FAST = 2'd0,
      CH_BASE = 2'd1,
      CH_SLOW = 2'd2
   } xls_ch_e;

   // preferred channel from class code and whether the payload fits the fast width
   function automatic xls_ch_e preferred_ch(input logic [2:0] cls, input logic fits);
      xls_ch_e ch;
      case (cls)
         CLS_NARROW:              ch = fits ? CH_FAST : CH_BASE;
         CLS_ADDRLO:              ch = CH_FAST;
         CLS_DISPATCH, CLS_STORE: ch = CH_SLOW;
         default:                 ch = CH_BASE;
      endcase
      return ch;
   endfunction

endpackage

// File: rtl/xls_steer.sv
module xls_steer
   import xls_pkg::*;
#(
   parameter int NREQ   = 2,
   parameter int DW     = 32,
   parameter int DSTW   = 2,
   parameter int FAST_W = 10,
   parameter int NF     = 1,
   parameter int NB     = 1,
   parameter int NS     = 2
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NREQ-1:0]                vld,
   input  logic [NREQ-1:0][CLS_W-1:0]     cls,
   input  logic [NREQ-1:0][DSTW-1:0]      dst,
   input  logic [NREQ-1:0][DW-1:0]        dat,
   output logic [NREQ-1:0]                rdy,
   output logic [NF-1:0]                  f_vld,
   output logic [NF-1:0][CLS_W-1:0]       f_cls,
   output logic [NF-1:0][DSTW-1:0]        f_dst,
   output logic [NF-1:0][DW-1:0]          f_dat,
   output logic [NB-1:0]                  b_vld,
   output logic [NB-1:0][CLS_W-1:0]       b_cls,
   output logic [NB-1:0][DSTW-1:0]        b_dst,
   output logic [NB-1:0][DW-1:0]          b_dat,
   output logic [NS-1:0]                  s_vld,
   output logic [NS-1:0][CLS_W-1:0]       s_cls,
   output logic [NS-1:0][DSTW-1:0]        s_dst,
   output logic [NS-1:0][DW-1:0]          s_dat
);

   localparam logic [DW-1:0] LOW_MASK = {{(DW-FAST_W){1'b0}}, {FAST_W{1'b1}}};

   always_comb begin
      int      nf;
      int      nb;
      int      ns;
      logic    blocked;
      logic    fits;
      xls_ch_e want;
      nf = 0;
      nb = 0;
      ns = 0;
      blocked = 1'b0;
      rdy   = '0;
      f_vld = '0; f_cls = '0; f_dst = '0; f_dat = '0;
      b_vld = '0; b_cls = '0; b_dst = '0; b_dat = '0;
      s_vld = '0; s_cls = '0; s_dst = '0; s_dat = '0;
      for (int i = 0; i < NREQ; i++) begin
         fits = ((dat[i] & ~LOW_MASK) == '0);
         want = preferred_ch(cls[i], fits);
         if (vld[i] && !blocked) begin
            if (want == CH_FAST && nf < NF) begin
               f_vld[nf] = 1'b1;
               f_cls[nf] = cls[i];
               f_dst[nf] = dst[i];
               f_dat[nf] = dat[i] & LOW_MASK;
               nf = nf + 1;
               rdy[i] = 1'b1;
            end else if (want == CH_SLOW && ns < NS) begin
               s_vld[ns] = 1'b1;
               s_cls[ns] = cls[i];
               s_dst[ns] = dst[i];
               s_dat[ns] = dat[i];
               ns = ns + 1;
               rdy[i] = 1'b1;
            end else if (nb < NB) begin
               b_vld[nb] = 1'b1;
               b_cls[nb] = cls[i];
               b_dst[nb] = dst[i];
               b_dat[nb] = dat[i];
               nb = nb + 1;
               rdy[i] = 1'b1;
            end else begin
               blocked = 1'b1;
            end
         end
      end
   end

   // lane ordering and backpressure checks
   for (genvar i = 0; i < NREQ; i++) begin : g_lane_chk
      if (i == 0) begin : g_first
         assert_stall_base_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (vld[0] && !rdy[0]) |-> (&b_vld));
      end else begin : g_rest
         assert_in_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
            rdy[i] |-> (&(rdy[i-1:0] | ~vld[i-1:0])));
         assert_stall_base_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (vld[i] && !rdy[i] && (&(rdy[i-1:0] | ~vld[i-1:0]))) |-> (&b_vld));
      end
      assert_rdy_needs_vld_R5: assert property (@(posedge clk) disable iff (!rst_n)
         rdy[i] |-> vld[i]);
   end

   // class policy checks on the slot vectors
   for (genvar k = 0; k < NF; k++) begin : g_fast_chk
      assert_fast_class_R1: assert property (@(posedge clk) disable iff (!rst_n)
         f_vld[k] |-> (f_cls[k] inside {CLS_NARROW, CLS_ADDRLO}));
   end
   for (genvar k = 0; k < NS; k++) begin : g_slow_chk
      assert_slow_class_R1: assert property (@(posedge clk) disable iff (!rst_n)
         s_vld[k] |-> (s_cls[k] inside {CLS_DISPATCH, CLS_STORE}));
   end

endmodule

// File: rtl/xls_delay_line.sv
module xls_delay_line #(
   parameter int LAT = 1,
   parameter int N   = 1,
   parameter int W   = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [N-1:0]          in_vld,
   input  logic [N-1:0][W-1:0]   in_pay,
   output logic [N-1:0]          out_vld,
   output logic [N-1:0][W-1:0]   out_pay
);

   if (LAT < 1 || LAT > 16) begin : g_bad_lat
      $error("xls_delay_line: LAT must lie in 1..16");
   end

   logic [LAT-1:0][N-1:0]         stg_v;
   logic [LAT-1:0][N-1:0][W-1:0]  stg_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_v <= '0;
         stg_p <= '0;
      end else begin
         stg_v[0] <= in_vld;
         stg_p[0] <= in_pay;
         for (int s = 1; s < LAT; s++) begin
            stg_v[s] <= stg_v[s-1];
            stg_p[s] <= stg_p[s-1];
         end
      end
   end

   assign out_vld = stg_v[LAT-1];
   assign out_pay = stg_p[LAT-1];

   for (genvar k = 0; k < N; k++) begin : g_lat_chk
      assert_pipe_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
         out_vld[k] |-> $past(in_vld[k], LAT));
   end

endmodule

// File: rtl/xls_link_steer.sv
module xls_link_steer
   import xls_pkg::*;
#(
   parameter int NREQ   = 2,
   parameter int DW     = 32,
   parameter int DSTW   = 2,
   parameter int FAST_W = 10,
   parameter int NF     = 1,
   parameter int NB     = 1,
   parameter int NS     = 2,
   parameter bit RING   = 1'b0
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic [NREQ-1:0]                    req_vld,
   input  logic [NREQ*CLS_W-1:0]              req_cls,
   input  logic [NREQ*DSTW-1:0]               req_dst,
   input  logic [NREQ*DW-1:0]                 req_dat,
   output logic [NREQ-1:0]                    req_rdy,
   output logic [NF+NB+NS-1:0]                out_vld,
   output logic [(NF+NB+NS)*CLS_W-1:0]        out_cls,
   output logic [(NF+NB+NS)*DSTW-1:0]         out_dst,
   output logic [(NF+NB+NS)*DW-1:0]           out_dat
);

   localparam int LAT_F = RING ? 2 : 1;
   localparam int LAT_B = RING ? 4 : 2;
   localparam int LAT_S = RING ? 6 : 3;
   localparam int PW    = CLS_W + DSTW + DW;
   localparam int B0    = NF;
   localparam int S0    = NF + NB;

   if (NREQ < 1 || NF < 1 || NB < 1 || NS < 1) begin : g_bad_cnt
      $error("xls_link_steer: lane and slot counts must be at least 1");
   end
   if (FAST_W < 1 || FAST_W >= DW) begin : g_bad_fw
      $error("xls_link_steer: FAST_W must lie in 1..DW-1");
   end
   if (DSTW < 1) begin : g_bad_dst
      $error("xls_link_steer: DSTW must be at least 1");
   end

   logic [NREQ-1:0][CLS_W-1:0] lane_cls;
   logic [NREQ-1:0][DSTW-1:0]  lane_dst;
   logic [NREQ-1:0][DW-1:0]    lane_dat;

   assign lane_cls = req_cls;
   assign lane_dst = req_dst;
   assign lane_dat = req_dat;

   logic [NF-1:0]              f_vld;
   logic [NF-1:0][CLS_W-1:0]   f_cls;
   logic [NF-1:0][DSTW-1:0]    f_dst;
   logic [NF-1:0][DW-1:0]      f_dat;
   logic [NB-1:0]              b_vld;
   logic [NB-1:0][CLS_W-1:0]   b_cls;
   logic [NB-1:0][DSTW-1:0]    b_dst;
   logic [NB-1:0][DW-1:0]      b_dat;
   logic [NS-1:0]              s_vld;
   logic [NS-1:0][CLS_W-1:0]   s_cls;
   logic [NS-1:0][DSTW-1:0]    s_dst;
   logic [NS-1:0][DW-1:0]      s_dat;

   xls_steer #(
      .NREQ(NREQ), .DW(DW), .DSTW(DSTW), .FAST_W(FAST_W),
      .NF(NF), .NB(NB), .NS(NS)
   ) u_steer (
      .clk(clk), .rst_n(rst_n),
      .vld(req_vld), .cls(lane_cls), .dst(lane_dst), .dat(lane_dat),
      .rdy(req_rdy),
      .f_vld(f_vld), .f_cls(f_cls), .f_dst(f_dst), .f_dat(f_dat),
      .b_vld(b_vld), .b_cls(b_cls), .b_dst(b_dst), .b_dat(b_dat),
      .s_vld(s_vld), .s_cls(s_cls), .s_dst(s_dst), .s_dat(s_dat)
   );

   logic [NF-1:0][PW-1:0] f_pay, fo_pay;
   logic [NB-1:0][PW-1:0] b_pay, bo_pay;
   logic [NS-1:0][PW-1:0] s_pay, so_pay;
   logic [NF-1:0]         fo_vld;
   logic [NB-1:0]         bo_vld;
   logic [NS-1:0]         so_vld;

   for (genvar k = 0; k < NF; k++) begin : g_fpack
      assign f_pay[k] = {f_cls[k], f_dst[k], f_dat[k]};
   end
   for (genvar k = 0; k < NB; k++) begin : g_bpack
      assign b_pay[k] = {b_cls[k], b_dst[k], b_dat[k]};
   end
   for (genvar k = 0; k < NS; k++) begin : g_spack
      assign s_pay[k] = {s_cls[k], s_dst[k], s_dat[k]};
   end

   xls_delay_line #(.LAT(LAT_F), .N(NF), .W(PW)) u_fast_line (
      .clk(clk), .rst_n(rst_n), .in_vld(f_vld), .in_pay(f_pay),
      .out_vld(fo_vld), .out_pay(fo_pay));

   xls_delay_line #(.LAT(LAT_B), .N(NB), .W(PW)) u_base_line (
      .clk(clk), .rst_n(rst_n), .in_vld(b_vld), .in_pay(b_pay),
      .out_vld(bo_vld), .out_pay(bo_pay));

   xls_delay_line #(.LAT(LAT_S), .N(NS), .W(PW)) u_slow_line (
      .clk(clk), .rst_n(rst_n), .in_vld(s_vld), .in_pay(s_pay),
      .out_vld(so_vld), .out_pay(so_pay));

   for (genvar k = 0; k < NF; k++) begin : g_fout
      assign out_vld[k] = fo_vld[k];
      assign {out_cls[k*CLS_W +: CLS_W], out_dst[k*DSTW +: DSTW], out_dat[k*DW +: DW]} = fo_pay[k];
      assert_fast_low_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
         out_vld[k] |-> (out_dat[k*DW+FAST_W +: DW-FAST_W] == '0));
   end
   for (genvar k = 0; k < NB; k++) begin : g_bout
      assign out_vld[B0+k] = bo_vld[k];
      assign {out_cls[(B0+k)*CLS_W +: CLS_W], out_dst[(B0+k)*DSTW +: DSTW],
              out_dat[(B0+k)*DW +: DW]} = bo_pay[k];
   end
   for (genvar k = 0; k < NS; k++) begin : g_sout
      assign out_vld[S0+k] = so_vld[k];
      assign {out_cls[(S0+k)*CLS_W +: CLS_W], out_dst[(S0+k)*DSTW +: DSTW],
              out_dat[(S0+k)*DW +: DW]} = so_pay[k];
   end

endmodule

// File: tb/xls_link_steer_tb.sv
module xls_link_steer_tb;

   localparam int CLK_PERIOD = 10;
   localparam int NREQ  = 2;
   localparam int DW    = 32;
   localparam int DSTW  = 2;
   localparam int FW    = 10;
   localparam int NSLOT = 4;
   localparam int MAX_CYC = 100000;

   logic clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic                    rst_n;
   logic [NREQ-1:0]         req_vld;
   logic [NREQ*3-1:0]       req_cls;
   logic [NREQ*DSTW-1:0]    req_dst;
   logic [NREQ*DW-1:0]      req_dat;
   logic [NREQ-1:0]         x_rdy, r_rdy;
   logic [NSLOT-1:0]        x_vld, r_vld;
   logic [NSLOT*3-1:0]      x_cls, r_cls;
   logic [NSLOT*DSTW-1:0]   x_dst, r_dst;
   logic [NSLOT*DW-1:0]     x_dat, r_dat;

   xls_link_steer #(.RING(1'b0)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_cls(req_cls),
      .req_dst(req_dst), .req_dat(req_dat), .req_rdy(x_rdy),
      .out_vld(x_vld), .out_cls(x_cls), .out_dst(x_dst), .out_dat(x_dat));

   xls_link_steer #(.RING(1'b1)) u_ring (
      .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_cls(req_cls),
      .req_dst(req_dst), .req_dat(req_dat), .req_rdy(r_rdy),
      .out_vld(r_vld), .out_cls(r_cls), .out_dst(r_dst), .out_dat(r_dat));

   int n_checks = 0;
   int n_fail   = 0;
   int cyc      = 0;

   // expected results of one vector
   logic        exp_v   [NSLOT];
   logic [2:0]  exp_cls [NSLOT];
   logic [1:0]  exp_dst [NSLOT];
   logic [31:0] exp_dat [NSLOT];
   string       slot_tag[NSLOT];
   logic        exp_rdy [NREQ];
   string       rdy_tag [NREQ];

   logic [2:0]  ln_c [NREQ];
   logic [1:0]  ln_d [NREQ];
   logic [31:0] ln_p [NREQ];

   task automatic check(input bit ok, input string tag, input string what,
                        input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // channel choice from the requirements: fast slot 0, base slot 1, slow slots 2..3
   task automatic plan(input logic [NREQ-1:0] v);
      int  free_f;
      int  free_b;
      int  free_s;
      bit  blocked;
      free_f = 1; free_b = 1; free_s = 2; blocked = 1'b0;
      for (int s = 0; s < NSLOT; s++) begin
         exp_v[s] = 1'b0; exp_cls[s] = '0; exp_dst[s] = '0; exp_dat[s] = '0;
         slot_tag[s] = "R4";
      end
      for (int i = 0; i < NREQ; i++) begin
         bit    fits;
         int    pref;
         int    slot;
         string t;
         exp_rdy[i] = 1'b0;
         rdy_tag[i] = "R6";
         if (v[i] && !blocked) begin
            fits = (ln_p[i][31:FW] == '0);
            if (ln_c[i] == 3'd1) pref = fits ? 0 : 1;
            else if (ln_c[i] == 3'd4) pref = 0;
            else if (ln_c[i] == 3'd2 || ln_c[i] == 3'd3) pref = 2;
            else pref = 1;
            t = (ln_c[i] == 3'd1 && !fits) ? "R2" : "R1";
            slot = -1;
            if (pref == 0 && free_f > 0) begin
               slot = 0; free_f--;
               if (ln_c[i] == 3'd4) t = "R3";
            end else if (pref == 2 && free_s > 0) begin
               slot = 2 + (2 - free_s); free_s--;
            end else if (free_b > 0) begin
               slot = 1; free_b--;
               if (pref != 1) t = "R4";
            end else begin
               blocked = 1'b1;
               rdy_tag[i] = "R5";
            end
            if (slot >= 0) begin
               exp_rdy[i]     = 1'b1;
               rdy_tag[i]     = t;
               exp_v[slot]    = 1'b1;
               exp_cls[slot]  = ln_c[i];
               exp_dst[slot]  = ln_d[i];
               exp_dat[slot]  = (slot == 0) ? (ln_p[i] & 32'h0000_03FF) : ln_p[i];
               slot_tag[slot] = t;
            end
         end else if (v[i]) begin
            rdy_tag[i] = "R6";
         end else begin
            rdy_tag[i] = "R5";
         end
      end
   endtask

   task automatic check_slots(input int k);
      for (int s = 0; s < NSLOT; s++) begin
         int lat_x;
         lat_x = (s == 0) ? 1 : (s == 1) ? 2 : 3;
         for (int r = 0; r < 2; r++) begin
            int    lat;
            bit    ev;
            bit    av;
            bit    ok;
            logic [2:0]  ac;
            logic [1:0]  ad;
            logic [31:0] ap;
            string lt;
            lat = (r == 1) ? 2 * lat_x : lat_x;
            ev  = exp_v[s] && (k == lat);
            av  = (r == 1) ? r_vld[s] : x_vld[s];
            ac  = (r == 1) ? r_cls[s*3 +: 3] : x_cls[s*3 +: 3];
            ad  = (r == 1) ? r_dst[s*DSTW +: DSTW] : x_dst[s*DSTW +: DSTW];
            ap  = (r == 1) ? r_dat[s*DW +: DW] : x_dat[s*DW +: DW];
            ok  = (av == ev) && (!ev || (ac == exp_cls[s] && ad == exp_dst[s] && ap == exp_dat[s]));
            if (exp_v[s] && k > lat) lt = "R10";
            else lt = (r == 1) ? "R8" : "R7";
            check(ok, $sformatf("%s/%s/R9", slot_tag[s], lt),
                  $sformatf("slot %0d cycle %0d ring %0d vld,cls,dst,dat", s, k, r),
                  {31'(av), ac, ad, ap}, {31'(ev), exp_cls[s], exp_dst[s], exp_dat[s]});
         end
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > MAX_CYC) begin
         n_fail++;
         $display("FAIL R10 watchdog: actual %0d cycles expected below %0d", cyc, MAX_CYC);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      int vidx;
      rst_n   = 1'b0;
      req_vld = '0;
      req_cls = '0;
      req_dst = '0;
      req_dat = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(x_vld == '0, "R10", "crossbar slots after reset", longint'(x_vld), 0);
      check(r_vld == '0, "R10", "ring slots after reset", longint'(r_vld), 0);
      check(x_rdy == '0, "R5", "ready with no request", longint'(x_rdy), 0);

      vidx = 0;
      for (int cv = 1; cv <= 3; cv++) begin
         for (int c0 = 0; c0 <= 5; c0++) begin
            for (int c1 = 0; c1 <= 5; c1++) begin
               for (int w = 0; w <= 3; w++) begin
                  vidx++;
                  @(negedge clk);
                  for (int i = 0; i < NREQ; i++) begin
                     ln_c[i] = (i == 0) ? 3'(c0) : 3'(c1);
                     ln_d[i] = 2'(vidx + i);
                     if (w[i])
                        ln_p[i] = 32'hC000_0000 | 32'(vidx << 4) | 32'(i);
                     else
                        ln_p[i] = 32'((vidx * 3 + i) & 32'h3FF);
                     req_cls[i*3 +: 3]       = ln_c[i];
                     req_dst[i*DSTW +: DSTW] = ln_d[i];
                     req_dat[i*DW +: DW]     = ln_p[i];
                  end
                  req_vld = 2'(cv);
                  plan(2'(cv));
                  #1;
                  for (int i = 0; i < NREQ; i++) begin
                     check(x_rdy[i] == exp_rdy[i], rdy_tag[i], $sformatf("crossbar ready lane %0d", i),
                           longint'(x_rdy[i]), longint'(exp_rdy[i]));
                     check(r_rdy[i] == exp_rdy[i], rdy_tag[i], $sformatf("ring ready lane %0d", i),
                           longint'(r_rdy[i]), longint'(exp_rdy[i]));
                  end
                  @(negedge clk);
                  req_vld = '0;
                  for (int k = 1; k <= 7; k++) begin
                     if (k > 1) @(negedge clk);
                     check_slots(k);
                  end
               end
            end
         end
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule